// File: doc/BRIEF.md
# Operate-Class Micro-Operation Unit

This unit carries out the second cycle of an operate-class instruction for an 18-bit accumulator (AC), memory buffer (MBR) and live register (LR). The current AC and LR values come in together with a 13-bit micro-operation field, an 18-bit toggle-switch word and an 18-bit buffer-register word. The unit combines them through a chain of phases in a fixed order. It first clears the MBR and merges the switches. It then copies into the MBR and complements. After that come the LR transfers and logic, the shift or rotate, the half add and finally the carry add. Each phase sees the result of the phases before it.

The whole chain is combinational. When `start` is high on a rising clock edge, the new AC, MBR and LR are latched together. `done` then pulses high for the one following cycle. The outputs hold their values until the next start. Before the LR phase the MBR value is saved. As a result, when both transfer codes are requested together, LR and MBR exchange their values instead of one overwriting the other. Light-pen codes are accepted and do nothing.

Top module: `opr_unit`

## Requirements
- R1: After reset, `ac_out`, `mbr_out` and `lr_out` are zero and `done` is low.
- R2: Results are registered on the edge where `start` is high. `done` is high in the following cycle only. While `start` is low the three outputs keep their values.
- R3: The MBR starts every operation at zero. When `field & 0o104 == 0o004`, every set bit of `tsw_in` is ORed into AC. The light-pen code (`field & 0o104 == 0o100`) changes nothing.
- R4: `field[1:0]==1` copies AC into MBR. `field[1:0]==3` ORs `tbr_in` into MBR.
- R5: `field[5]` inverts all 18 AC bits. This happens after the AC-to-MBR copy, so the MBR holds the value from before the inversion.
- R6: The MBR value is saved before the LR phase. `field[1:0]==2` loads MBR from LR. `field[8:7]==1` loads LR from the saved MBR value. Requesting both exchanges the two registers.
- R7: When `field & 0o704 == 0o104`, LR is ORed with the saved MBR value. When it is `0o304`, LR is ANDed with the saved value. Because that code also has `field[8:7]==1`, LR ends equal to the saved value.
- R8: `field[8:7]==2` shifts AC right one place with a zero fill. `field[8:7]==3` rotates AC right one place, with bit 0 moving into bit 17.
- R9: `field[4]` XORs the final MBR into AC after the shift phase.
- R10: `field[3]` XORs the MBR into AC and then adds the MBR with end-around carry. The result is kept to 18 bits.
- R11: Phases apply in the order switch-merge, MBR setup and complement, LR phase, shift, half add, carry add. Each phase uses the results of the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch the computed results on this edge |
| field | input | 13 | Micro-operation field |
| ac_in | input | 18 | Current accumulator |
| lr_in | input | 18 | Current live register |
| tsw_in | input | 18 | Toggle-switch word |
| tbr_in | input | 18 | Buffer-register word |
| ac_out | output | 18 | Updated accumulator |
| mbr_out | output | 18 | Updated memory buffer |
| lr_out | output | 18 | Updated live register |
| done | output | 1 | One-cycle strobe after a start |

## Verification
The bench targets the exchange code. A design that fails to save the MBR before the LR phase would copy LR back into itself and lose the exchange. It also checks that the inversion follows the AC-to-MBR copy: an inversion placed earlier would leave an all-zero AC in the copy-invert-half-add case instead of all ones. The carry add is driven so that bit 17 overflows. A design without end-around carry would then return 0 instead of 1. The rotate case checks that bit 0 reaches bit 17, which a plain shift would drop. The light-pen and hold cases confirm that nothing moves when it should not.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned WORD_W  = 18;
  localparam int unsigned FIELD_W = 13;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_LOAD = 2'd1,
    MOVE_SHR  = 2'd2,
    MOVE_ROR  = 2'd3
  } move_e;

  typedef struct packed {
    logic  sw_merge;
    logic  ac_to_mbr;
    logic  tbr_to_mbr;
    logic  invert;
    logic  lr_to_mbr;
    logic  mbr_to_lr;
    logic  lr_or;
    logic  lr_and;
    move_e move;
    logic  half_add;
    logic  carry_add;
  } ctl_t;

  function automatic word_t shift_right(input word_t v);
    return {1'b0, v[WORD_W-1:1]};
  endfunction

  function automatic word_t rotate_right(input word_t v);
    return {v[0], v[WORD_W-1:1]};
  endfunction

  function automatic word_t add_wrap(input word_t a, input word_t b);
    logic [WORD_W:0] s;
    logic [WORD_W:0] t;
    s = {1'b0, a} + {1'b0, b};
    t = {1'b0, s[WORD_W-1:0]} + {{WORD_W{1'b0}}, s[WORD_W]};
    return t[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  field_t field,
  output ctl_t   ctl
);
  logic [1:0] low_sel;
  logic [1:0] move_sel;

  assign low_sel  = field[1:0];
  assign move_sel = field[8:7];

  always_comb begin
    ctl            = '0;
    ctl.sw_merge   = (field[6] == 1'b0) && (field[2] == 1'b1);
    ctl.ac_to_mbr  = (low_sel == 2'd1);
    ctl.tbr_to_mbr = (low_sel == 2'd3);
    ctl.lr_to_mbr  = (low_sel == 2'd2);
    ctl.invert     = field[5];
    ctl.move       = move_e'(move_sel);
    ctl.mbr_to_lr  = (move_sel == 2'd1);
    ctl.lr_or      = (field[8:6] == 3'b001) && field[2];
    ctl.lr_and     = (field[8:6] == 3'b011) && field[2];
    ctl.half_add   = field[4];
    ctl.carry_add  = field[3];
  end
endmodule

// File: rtl/opr_front.sv
module opr_front
  import opr_pkg::*;
(
  input  ctl_t  ctl,
  input  word_t ac_in,
  input  word_t tsw_in,
  input  word_t tbr_in,
  output word_t ac_mid,
  output word_t mbr_mid
);
  word_t ac_sw;
  word_t mbr_copy;

  always_comb begin
    ac_sw = ctl.sw_merge ? (ac_in | tsw_in) : ac_in;
    mbr_copy = ctl.ac_to_mbr ? ac_sw : '0;
    ac_mid = ctl.invert ? ~ac_sw : ac_sw;
    mbr_mid = ctl.tbr_to_mbr ? (mbr_copy | tbr_in) : mbr_copy;
  end
endmodule

// File: rtl/opr_live.sv
module opr_live
  import opr_pkg::*;
(
  input  ctl_t  ctl,
  input  word_t mbr_mid,
  input  word_t lr_in,
  output word_t saved_mbr,
  output word_t mbr_fin,
  output word_t lr_fin
);
  word_t lr_a;
  word_t lr_b;

  assign saved_mbr = mbr_mid;

  always_comb begin
    mbr_fin = ctl.lr_to_mbr ? lr_in : mbr_mid;
    lr_a = ctl.mbr_to_lr ? saved_mbr : lr_in;
    lr_b = ctl.lr_or ? (lr_a | saved_mbr) : lr_a;
    lr_fin = ctl.lr_and ? (lr_b & saved_mbr) : lr_b;
  end
endmodule

// File: rtl/opr_back.sv
module opr_back
  import opr_pkg::*;
(
  input  ctl_t  ctl,
  input  word_t ac_mid,
  input  word_t mbr_fin,
  output word_t ac_fin
);
  word_t ac_mv;
  word_t ac_pad;
  word_t ac_x;

  always_comb begin
    unique case (ctl.move)
      MOVE_SHR: ac_mv = shift_right(ac_mid);
      MOVE_ROR: ac_mv = rotate_right(ac_mid);
      default:  ac_mv = ac_mid;
    endcase
    ac_pad = ctl.half_add ? (ac_mv ^ mbr_fin) : ac_mv;
    ac_x = ac_pad ^ mbr_fin;
    ac_fin = ctl.carry_add ? add_wrap(ac_x, mbr_fin) : ac_pad;
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] field,
  input  logic [WORD_W-1:0]  ac_in,
  input  logic [WORD_W-1:0]  lr_in,
  input  logic [WORD_W-1:0]  tsw_in,
  input  logic [WORD_W-1:0]  tbr_in,
  output logic [WORD_W-1:0]  ac_out,
  output logic [WORD_W-1:0]  mbr_out,
  output logic [WORD_W-1:0]  lr_out,
  output logic               done
);
  ctl_t  ctl;
  word_t ac_mid;
  word_t mbr_mid;
  word_t saved_mbr;
  word_t mbr_fin;
  word_t lr_fin;
  word_t ac_fin;

  opr_decode u_dec (.field(field), .ctl(ctl));

  opr_front u_front (
    .ctl(ctl), .ac_in(ac_in), .tsw_in(tsw_in), .tbr_in(tbr_in),
    .ac_mid(ac_mid), .mbr_mid(mbr_mid)
  );

  opr_live u_live (
    .ctl(ctl), .mbr_mid(mbr_mid), .lr_in(lr_in),
    .saved_mbr(saved_mbr), .mbr_fin(mbr_fin), .lr_fin(lr_fin)
  );

  opr_back u_back (
    .ctl(ctl), .ac_mid(ac_mid), .mbr_fin(mbr_fin), .ac_fin(ac_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_out  <= '0;
      mbr_out <= '0;
      lr_out  <= '0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        ac_out  <= ac_fin;
        mbr_out <= mbr_fin;
        lr_out  <= lr_fin;
      end
    end
  end
endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk
  import opr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [FIELD_W-1:0] field,
  input logic [WORD_W-1:0]  ac_in,
  input logic [WORD_W-1:0]  lr_in,
  input logic [WORD_W-1:0]  ac_out,
  input logic [WORD_W-1:0]  mbr_out,
  input logic [WORD_W-1:0]  lr_out,
  input logic               done,
  input logic [WORD_W-1:0]  saved_mbr
);
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(ac_out) && $stable(mbr_out) && $stable(lr_out)));

  a_r3_mbr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (start && field[1:0] == 2'd0) |=> (mbr_out == '0));

  a_r6_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    (start && field[1:0] == 2'd2 && field[8:6] == 3'b010)
      |=> (mbr_out == $past(lr_in) && lr_out == $past(saved_mbr)));

  a_r8_shift_only: assert property (@(posedge clk) disable iff (!rst_n)
    (start && field == 13'o0400) |=> (ac_out == {1'b0, $past(ac_in[WORD_W-1:1])}));
endmodule

bind opr_unit opr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .field(field),
  .ac_in(ac_in), .lr_in(lr_in), .ac_out(ac_out), .mbr_out(mbr_out),
  .lr_out(lr_out), .done(done), .saved_mbr(saved_mbr)
);

// File: tb/opr_unit_tb.sv
module opr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] ALL1 = 18'h3FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] field = '0;
  logic [17:0] ac_in = '0, lr_in = '0, tsw_in = '0, tbr_in = '0;
  logic [17:0] ac_out, mbr_out, lr_out;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .field(field),
    .ac_in(ac_in), .lr_in(lr_in), .tsw_in(tsw_in), .tbr_in(tbr_in),
    .ac_out(ac_out), .mbr_out(mbr_out), .lr_out(lr_out), .done(done)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  // Independent reference: walks the phases one statement at a time.
  task automatic model(input logic [12:0] f, input logic [17:0] a0, input logic [17:0] l0,
                       input logic [17:0] sw, input logic [17:0] tb,
                       output logic [17:0] a, output logic [17:0] m, output logic [17:0] l);
    logic [17:0] keep;
    logic [18:0] sum;
    a = a0; l = l0; m = 18'd0;
    if ((f & 13'o0104) == 13'o0004) a = a | sw;
    if (f[1:0] == 2'd1) m = a;
    if (f[5]) a = a ^ ALL1;
    if (f[1:0] == 2'd3) m = m | tb;
    keep = m;
    if (f[1:0] == 2'd2) m = l;
    if (f[8:7] == 2'd1) l = keep;
    if ((f & 13'o0704) == 13'o0104) l = l | keep;
    if ((f & 13'o0704) == 13'o0304) l = l & keep;
    if (f[8:7] == 2'd2) a = a / 2;
    if (f[8:7] == 2'd3) a = (a / 2) + (a[0] ? 18'h20000 : 18'h0);
    if (f[4]) a = a ^ m;
    if (f[3]) begin
      a = a ^ m;
      sum = a + m;
      sum = sum[17:0] + sum[18];
      a = sum[17:0];
    end
  endtask

  task automatic run_op(input logic [12:0] f, input logic [17:0] a0, input logic [17:0] l0,
                        input logic [17:0] sw, input logic [17:0] tb, input string req);
    logic [17:0] ea, em, el;
    model(f, a0, l0, sw, tb, ea, em, el);
    @(negedge clk);
    field = f; ac_in = a0; lr_in = l0; tsw_in = sw; tbr_in = tb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " done"}, {17'd0, done}, 18'd1);
    check({req, " ac"}, ac_out, ea);
    check({req, " mbr"}, mbr_out, em);
    check({req, " lr"}, lr_out, el);
  endtask

  task automatic t_reset();
    check("R1 ac", ac_out, 18'd0);
    check("R1 mbr", mbr_out, 18'd0);
    check("R1 lr", lr_out, 18'd0);
    check("R1 done", {17'd0, done}, 18'd0);
  endtask

  task automatic t_switch_merge();
    run_op(13'o0004, 18'o000700, 18'o1, 18'o070007, 18'o0, "R3 merge");
    check("R3 merge value", ac_out, 18'o070707);
    run_op(13'o0100, 18'o123456, 18'o654321, ALL1, ALL1, "R3 pen");
    check("R3 pen no effect ac", ac_out, 18'o123456);
    check("R3 pen mbr zero", mbr_out, 18'o0);
  endtask

  task automatic t_mbr_setup();
    run_op(13'o0001, 18'o135246, 18'o0, 18'o0, 18'o0, "R4 copy");
    check("R4 copy mbr", mbr_out, 18'o135246);
    run_op(13'o0003, 18'o1, 18'o0, 18'o0, 18'o707070, "R4 tbr");
    check("R4 tbr mbr", mbr_out, 18'o707070);
  endtask

  task automatic t_invert();
    run_op(13'o0041, 18'o000777, 18'o0, 18'o0, 18'o0, "R5 inv");
    check("R5 inv ac", ac_out, 18'o777000);
    check("R5 mbr pre-invert", mbr_out, 18'o000777);
  endtask

  task automatic t_exchange();
    run_op(13'o0202, 18'o5, 18'o424242, 18'o0, 18'o0, "R6 xchg");
    check("R6 mbr from lr", mbr_out, 18'o424242);
    check("R6 lr from saved", lr_out, 18'o0);
    run_op(13'o0203, 18'o0, 18'o1, 18'o0, 18'o333, "R6 tbr to lr");
    check("R6 lr takes saved tbr", lr_out, 18'o333);
  endtask

  task automatic t_lr_logic();
    run_op(13'o0105, 18'o000770, 18'o700007, 18'o0, 18'o0, "R7 or");
    check("R7 or lr", lr_out, 18'o700777);
    run_op(13'o0305, 18'o000770, 18'o700077, 18'o0, 18'o0, "R7 and");
    check("R7 and lr", lr_out, 18'o000770);
  endtask

  task automatic t_move();
    run_op(13'o0400, 18'o000003, 18'o0, 18'o0, 18'o0, "R8 shr");
    check("R8 shr ac", ac_out, 18'o000001);
    run_op(13'o0600, 18'o000003, 18'o0, 18'o0, 18'o0, "R8 ror");
    check("R8 ror ac", ac_out, 18'o400001);
  endtask

  task automatic t_half_add();
    run_op(13'o0023, 18'o770000, 18'o0, 18'o0, 18'o070707, "R9 pad");
    check("R9 pad ac", ac_out, 18'o700707);
  endtask

  task automatic t_carry();
    run_op(13'o0013, 18'o0, 18'o0, 18'o0, 18'o400000, "R10 wrap");
    check("R10 end-around", ac_out, 18'o000001);
    run_op(13'o0013, 18'o000005, 18'o0, 18'o0, 18'o000003, "R10 plain");
  endtask

  task automatic t_order();
    run_op(13'o0061, 18'o123456, 18'o0, 18'o0, 18'o0, "R11 copy-inv-pad");
    check("R11 all ones", ac_out, ALL1);
    run_op(13'o0637, 18'o111111, 18'o222222, 18'o0, 18'o444444, "R11 mixed");
  endtask

  task automatic t_hold();
    logic [17:0] a, m, l;
    a = ac_out; m = mbr_out; l = lr_out;
    @(negedge clk);
    field = 13'o0041; ac_in = ALL1; lr_in = ALL1; tsw_in = ALL1; tbr_in = ALL1;
    @(negedge clk);
    @(negedge clk);
    check("R2 done low", {17'd0, done}, 18'd0);
    check("R2 hold ac", ac_out, a);
    check("R2 hold mbr", mbr_out, m);
    check("R2 hold lr", lr_out, l);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_switch_merge();
        t_mbr_setup();
        t_invert();
        t_exchange();
        t_lr_logic();
        t_move();
        t_half_add();
        t_carry();
        t_order();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule